// File: doc/BRIEF.md
# Fibre Channel Link Synchronization Monitor

This block watches a receive stream of already decoded 8b/10b characters and decides whether the link is in word synchronization. One character arrives per clock on which `charValid` is high, with its data byte, a control-character flag, a comma-detect flag, a misaligned-comma flag and a code-violation flag (which also covers running-disparity errors). A word-boundary strobe marks the first character of each four-character word. When no strobe arrives, the block keeps counting in steps of four characters.

After reset the block hunts for synchronization. It declares lock once three idle ordered sets, each aligned to a word, arrive back to back with nothing between them. An idle ordered set is K28.5, D21.4, D21.5, D21.5. While locked, the block counts invalid words. Each run of two consecutive valid words removes one previously counted invalid word. A fourth uncancelled invalid word drops lock, and hunting starts again at the next word boundary. A separately held status bit follows the lock flag so that it can be read as a status field.

Top module: `fc_link_sync`

## Requirements
- R1: After reset both `syncOk` and `syncStatus` are 0.
- R2: Three consecutive idle ordered sets raise `syncOk` on the clock edge that samples the last character of the third set. A set is the control character 0xBC (K28.5) with `charIsK`=1 and `commaSeen`=1, followed by the data characters 0x95 (D21.4), 0xB5 and 0xB5 (D21.5), all with `charIsK`=0.
- R3: While hunting, a character with `codeViol`=1 or `commaMisaligned`=1 clears both the partial set match and the count of completed sets.
- R4: While hunting, a valid character that does not continue the idle pattern also clears the set count and the partial match. If that character is itself an aligned K28.5, a new set match starts from it.
- R5: An idle set counts only when its K28.5 sits in slot 0 of a word and its remaining characters sit in slots 1 to 3.
- R6: While locked, a word is invalid if any of its characters has `codeViol` or `commaMisaligned` set. `syncOk` falls on the edge that samples the last character of the fourth uncancelled invalid word.
- R7: While locked, two consecutive valid words cancel one counted invalid word. An invalid word clears a partial run of good words. The invalid count never goes below zero, so good words earn no credit in advance.
- R8: `syncStatus` equals `syncOk` on every cycle.
- R9: After lock is lost, three fresh idle sets are needed again, and the first of them may start at the very next word boundary.
- R10: A character slot is consumed only when `charValid` is 1. `wordBoundary` forces slot 0. Without the strobe, slots run 0 to 3 and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charValid | input | 1 | A character is present this cycle |
| charData | input | 8 | Decoded character byte |
| charIsK | input | 1 | Character is a control character |
| commaSeen | input | 1 | Comma pattern detected in this character |
| commaMisaligned | input | 1 | Comma found off its expected alignment |
| codeViol | input | 1 | Code or running-disparity violation |
| wordBoundary | input | 1 | Character is the first of a word |
| syncOk | output | 1 | Link is synchronized |
| syncStatus | output | 1 | Status copy of the lock flag, 0 when unsynchronized |

## Verification
The bench drives a clean idle stream, an idle stream broken by a single flawed character, by a valid non-idle word and by a K28.5 shifted one slot off the word boundary. A design that kept partial credit would lock too early in each of these cases. While locked, it checks the exact fourth invalid word that drops lock. It also checks an invalid/good/good pattern that must hold lock, and a long good stretch that must not bank credit. A design with a wrong threshold, a missing cancellation or a counter that goes below zero would drop lock one word early or late. Gaps in `charValid` and words framed with no boundary strobe show whether idle cycles are wrongly counted as characters.

// File: rtl/fc_link_sync_pkg.sv
package fc_link_sync_pkg;

  localparam logic [7:0] SYM_K28_5 = 8'hBC;
  localparam logic [7:0] SYM_D21_4 = 8'h95;
  localparam logic [7:0] SYM_D21_5 = 8'hB5;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } syncState_t;

  // control -> datapath
  typedef struct packed {
    logic matchRestart;
    logic matchStart;
    logic matchAdvance;
    logic idleClear;
    logic idleBump;
    logic badClear;
    logic badBump;
    logic badDrop;
    logic goodClear;
    logic goodBump;
    logic lockSet;
    logic lockClr;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic charBad;
    logic idleHit;
    logic startHit;
    logic setDone;
    logic acqDone;
    logic wordEnd;
    logic wordInvalid;
    logic lossHit;
    logic cancelHit;
  } dpFlag_t;

endpackage

// File: rtl/fc_link_sync_dp.sv
module fc_link_sync_dp
  import fc_link_sync_pkg::*;
#(
  parameter int WORD_CHARS = 4,
  parameter int ACQ_SETS   = 3,
  parameter int LOSS_WORDS = 4,
  parameter int CANCEL_RUN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic [7:0] charData,
  input  logic       charIsK,
  input  logic       commaSeen,
  input  logic       commaMisaligned,
  input  logic       codeViol,
  input  logic       wordBoundary,
  input  ctlStrobe_t strobe,
  output dpFlag_t    flag,
  output logic       statusBit
);

  localparam int POS_W  = (WORD_CHARS > 1) ? $clog2(WORD_CHARS) : 1;
  localparam int IDLE_W = $clog2(ACQ_SETS + 1);
  localparam int BAD_W  = $clog2(LOSS_WORDS + 1);
  localparam int GOOD_W = $clog2(CANCEL_RUN + 1);
  localparam logic [POS_W-1:0]  LAST_SLOT = POS_W'(WORD_CHARS - 1);

  logic [POS_W-1:0]  slotIdx, curSlot, matchPos;
  logic [IDLE_W-1:0] idleCnt;
  logic [BAD_W-1:0]  badCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic              wordBad, wordBadNow, statusQ;
  logic [7:0]        expData;

  // word framing
  assign curSlot    = wordBoundary ? '0 : slotIdx;
  assign wordBadNow = (wordBoundary ? 1'b0 : wordBad) | codeViol | commaMisaligned;

  always_comb begin
    if (matchPos == POS_W'(1)) expData = SYM_D21_4;
    else                       expData = SYM_D21_5;
  end

  assign flag.charBad     = codeViol | commaMisaligned;
  assign flag.startHit    = (curSlot == '0) && commaSeen && charIsK && (charData == SYM_K28_5);
  assign flag.idleHit     = (matchPos == '0) ? flag.startHit
                          : (!charIsK && (charData == expData) && (curSlot == matchPos));
  assign flag.setDone     = flag.idleHit && (matchPos == LAST_SLOT);
  assign flag.acqDone     = flag.setDone && (idleCnt == IDLE_W'(ACQ_SETS - 1));
  assign flag.wordEnd     = charValid && (curSlot == LAST_SLOT);
  assign flag.wordInvalid = wordBadNow;
  assign flag.lossHit     = (badCnt == BAD_W'(LOSS_WORDS - 1));
  assign flag.cancelHit   = (goodCnt == GOOD_W'(CANCEL_RUN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
      wordBad <= 1'b0;
    end else if (charValid) begin
      slotIdx <= flag.wordEnd ? '0 : curSlot + POS_W'(1);
      wordBad <= flag.wordEnd ? 1'b0 : wordBadNow;
    end
  end

  // idle ordered-set matcher
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPos <= '0;
      idleCnt  <= '0;
    end else begin
      if (strobe.matchRestart)      matchPos <= '0;
      else if (strobe.matchStart)   matchPos <= POS_W'(1);
      else if (strobe.matchAdvance) matchPos <= matchPos + POS_W'(1);

      if (strobe.idleClear)     idleCnt <= '0;
      else if (strobe.idleBump) idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

  // invalid-word and good-run counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badCnt  <= '0;
      goodCnt <= '0;
    end else begin
      if (strobe.badClear)                       badCnt <= '0;
      else if (strobe.badBump)                   badCnt <= badCnt + BAD_W'(1);
      else if (strobe.badDrop && badCnt != '0)   badCnt <= badCnt - BAD_W'(1);

      if (strobe.goodClear)     goodCnt <= '0;
      else if (strobe.goodBump) goodCnt <= goodCnt + GOOD_W'(1);
    end
  end

  // status copy held apart from the state register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              statusQ <= 1'b0;
    else if (strobe.lockSet) statusQ <= 1'b1;
    else if (strobe.lockClr) statusQ <= 1'b0;
  end

  assign statusBit = statusQ;

endmodule

// File: rtl/fc_link_sync_ctl.sv
module fc_link_sync_ctl
  import fc_link_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  dpFlag_t    flag,
  output ctlStrobe_t strobe,
  output logic       locked
);

  syncState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (charValid) begin
      unique case (state)
        ST_HUNT: begin
          if (flag.charBad) begin
            strobe.idleClear    = 1'b1;
            strobe.matchRestart = 1'b1;
          end else if (flag.idleHit) begin
            if (flag.acqDone) begin
              stateNext           = ST_LOCK;
              strobe.lockSet      = 1'b1;
              strobe.idleClear    = 1'b1;
              strobe.matchRestart = 1'b1;
              strobe.badClear     = 1'b1;
              strobe.goodClear    = 1'b1;
            end else if (flag.setDone) begin
              strobe.idleBump     = 1'b1;
              strobe.matchRestart = 1'b1;
            end else begin
              strobe.matchAdvance = 1'b1;
            end
          end else begin
            strobe.idleClear = 1'b1;
            if (flag.startHit) strobe.matchStart   = 1'b1;
            else               strobe.matchRestart = 1'b1;
          end
        end
        ST_LOCK: begin
          if (flag.wordEnd) begin
            if (flag.wordInvalid) begin
              strobe.goodClear = 1'b1;
              if (flag.lossHit) begin
                stateNext           = ST_HUNT;
                strobe.lockClr      = 1'b1;
                strobe.badClear     = 1'b1;
                strobe.idleClear    = 1'b1;
                strobe.matchRestart = 1'b1;
              end else begin
                strobe.badBump = 1'b1;
              end
            end else if (flag.cancelHit) begin
              strobe.goodClear = 1'b1;
              strobe.badDrop   = 1'b1;
            end else begin
              strobe.goodBump = 1'b1;
            end
          end
        end
        default: stateNext = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= stateNext;
  end

  assign locked = (state == ST_LOCK);

endmodule

// File: rtl/fc_link_sync.sv
module fc_link_sync
  import fc_link_sync_pkg::*;
#(
  parameter int WORD_CHARS = 4,
  parameter int ACQ_SETS   = 3,
  parameter int LOSS_WORDS = 4,
  parameter int CANCEL_RUN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic [7:0] charData,
  input  logic       charIsK,
  input  logic       commaSeen,
  input  logic       commaMisaligned,
  input  logic       codeViol,
  input  logic       wordBoundary,
  output logic       syncOk,
  output logic       syncStatus
);

  ctlStrobe_t strobe;
  dpFlag_t    flag;

  fc_link_sync_dp #(
    .WORD_CHARS(WORD_CHARS),
    .ACQ_SETS  (ACQ_SETS),
    .LOSS_WORDS(LOSS_WORDS),
    .CANCEL_RUN(CANCEL_RUN)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .charValid      (charValid),
    .charData       (charData),
    .charIsK        (charIsK),
    .commaSeen      (commaSeen),
    .commaMisaligned(commaMisaligned),
    .codeViol       (codeViol),
    .wordBoundary   (wordBoundary),
    .strobe         (strobe),
    .flag           (flag),
    .statusBit      (syncStatus)
  );

  fc_link_sync_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .charValid(charValid),
    .flag     (flag),
    .strobe   (strobe),
    .locked   (syncOk)
  );

endmodule

// File: rtl/fc_link_sync_chk.sv
module fc_link_sync_chk #(
  parameter int WORD_CHARS = 4,
  parameter int ACQ_SETS   = 3,
  parameter int LOSS_WORDS = 4
) (
  input logic clk,
  input logic rstN,
  input logic charValid,
  input logic commaMisaligned,
  input logic codeViol,
  input logic syncOk,
  input logic syncStatus
);

  logic [15:0] cleanRun;
  logic [15:0] flawSeen;

  // clean characters since the last flawed one (saturating)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cleanRun <= '0;
    else if (charValid) begin
      if (codeViol || commaMisaligned) cleanRun <= '0;
      else if (cleanRun != 16'hFFFF)   cleanRun <= cleanRun + 16'd1;
    end
  end

  // flawed characters seen while locked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   flawSeen <= '0;
    else if (!syncOk)            flawSeen <= '0;
    else if (charValid && (codeViol || commaMisaligned) && flawSeen != 16'hFFFF)
      flawSeen <= flawSeen + 16'd1;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_low_R1: assert (syncOk == 1'b0 && syncStatus == 1'b0);
    end
  end

  assert_status_mirror_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncStatus == syncOk);

  assert_lock_needs_clean_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOk) |-> (cleanRun >= 16'(WORD_CHARS * ACQ_SETS)));

  assert_loss_needs_flaws_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncOk) |-> (flawSeen >= 16'(LOSS_WORDS)));

  assert_idle_cycle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !charValid |=> $stable(syncOk));

  assert_change_on_char_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(syncOk) || $fell(syncOk)) |-> $past(charValid));

endmodule

bind fc_link_sync fc_link_sync_chk #(
  .WORD_CHARS(WORD_CHARS),
  .ACQ_SETS  (ACQ_SETS),
  .LOSS_WORDS(LOSS_WORDS)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .charValid      (charValid),
  .commaMisaligned(commaMisaligned),
  .codeViol       (codeViol),
  .syncOk         (syncOk),
  .syncStatus     (syncStatus)
);

// File: tb/fc_link_sync_test.sv
`timescale 1ns/1ps
module fc_link_sync_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       charValid = 1'b0;
  logic [7:0] charData = 8'h00;
  logic       charIsK = 1'b0;
  logic       commaSeen = 1'b0;
  logic       commaMisaligned = 1'b0;
  logic       codeViol = 1'b0;
  logic       wordBoundary = 1'b0;
  logic       syncOk, syncStatus;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fc_link_sync uut (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .charIsK(charIsK), .commaSeen(commaSeen), .commaMisaligned(commaMisaligned),
    .codeViol(codeViol), .wordBoundary(wordBoundary),
    .syncOk(syncOk), .syncStatus(syncStatus)
  );

  // ---------------- behavioural reference ----------------
  int  mSlot = 0, mWant = 0, mSets = 0, mBad = 0, mGood = 0;
  bit  mWordBad = 0, mSync = 0;

  function automatic bit isIdleAt(int pos, int slot, bit k, logic [7:0] d, bit cm);
    if (slot != pos) return 0;
    case (pos)
      0: return k && cm && d == 8'hBC;
      1: return !k && d == 8'h95;
      default: return !k && d == 8'hB5;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSlot = 0; mWant = 0; mSets = 0; mBad = 0; mGood = 0; mWordBad = 0; mSync = 0;
    end else if (charValid) begin
      int  s;
      bit  flaw, wb, last;
      s    = wordBoundary ? 0 : mSlot;
      flaw = codeViol || commaMisaligned;
      wb   = (wordBoundary ? 1'b0 : mWordBad) || flaw;
      last = (s == 3);
      if (!mSync) begin
        if (flaw) begin
          mSets = 0; mWant = 0;
        end else if (isIdleAt(mWant, s, charIsK, charData, commaSeen)) begin
          if (mWant == 3) begin
            mWant = 0; mSets++;
            if (mSets == 3) begin mSync = 1; mSets = 0; mBad = 0; mGood = 0; end
          end else mWant++;
        end else begin
          mSets = 0;
          mWant = isIdleAt(0, s, charIsK, charData, commaSeen) ? 1 : 0;
        end
      end else if (last) begin
        if (wb) begin
          mGood = 0; mBad++;
          if (mBad == 4) begin mSync = 0; mBad = 0; mSets = 0; mWant = 0; end
        end else begin
          mGood++;
          if (mGood == 2) begin mGood = 0; if (mBad > 0) mBad--; end
        end
      end
      mSlot    = last ? 0 : s + 1;
      mWordBad = last ? 1'b0 : wb;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (syncOk !== mSync) begin
        errors++;
        $display("FAIL R2 model compare t=%0t syncOk=%0b expected %0b", $time, syncOk, mSync);
      end
      checks++;
      if (syncStatus !== mSync) begin
        errors++;
        $display("FAIL R8 model compare t=%0t syncStatus=%0b expected %0b", $time, syncStatus, mSync);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic sendChar(input bit k, input logic [7:0] d, input bit cm,
                          input bit mis, input bit cv, input bit wb);
    charValid = 1; charIsK = k; charData = d; commaSeen = cm;
    commaMisaligned = mis; codeViol = cv; wordBoundary = wb;
    @(posedge clk); @(negedge clk);
    charValid = 0; charIsK = 0; charData = 8'h00; commaSeen = 0;
    commaMisaligned = 0; codeViol = 0; wordBoundary = 0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // idle ordered set; flawAt selects a character to flag (-1 none), gapN idle cycles between chars
  task automatic sendIdle(input int flawAt = -1, input bit useMis = 0, input int gapN = 0);
    sendChar(1, 8'hBC, 1, (flawAt == 0) && useMis, (flawAt == 0) && !useMis, 1); gap(gapN);
    sendChar(0, 8'h95, 0, (flawAt == 1) && useMis, (flawAt == 1) && !useMis, 0); gap(gapN);
    sendChar(0, 8'hB5, 0, (flawAt == 2) && useMis, (flawAt == 2) && !useMis, 0); gap(gapN);
    sendChar(0, 8'hB5, 0, (flawAt == 3) && useMis, (flawAt == 3) && !useMis, 0); gap(gapN);
  endtask

  task automatic sendWord(input bit bad, input bit strobe = 1, input bit useMis = 0);
    for (int i = 0; i < 4; i++)
      sendChar(0, 8'h4A + 8'(i), 0, bad && useMis && i == 1, bad && !useMis && i == 1,
               strobe && i == 0);
  endtask

  task automatic expectSync(input bit exp, input string tag);
    checks++;
    if (syncOk !== exp || syncStatus !== exp) begin
      errors++;
      $display("FAIL %s syncOk=%0b syncStatus=%0b expected %0b", tag, syncOk, syncStatus, exp);
    end
  endtask

  task automatic acquire(input string tag);
    sendIdle(); sendIdle(); expectSync(0, tag);
    sendIdle(); expectSync(1, tag);
  endtask

  task automatic loseSync(input string tag, input bit strobe = 1);
    sendWord(1, strobe); sendWord(1, strobe); sendWord(1, strobe);
    expectSync(1, tag);
    sendWord(1, strobe, 1);
    expectSync(0, tag);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    gap(3);
    expectSync(0, "R1 reset state");
    rstN = 1;
    gap(2);
    expectSync(0, "R1 after reset release");

    // R2 plain acquisition
    acquire("R2 three idle sets");

    // R6 loss after four invalid words
    loseSync("R6 fourth invalid word");
    expectSync(0, "R8 status low after loss");

    // R9 immediate reacquisition
    acquire("R9 reacquire at next boundary");

    // R7 cancellation: bad, good, good, bad, bad, bad holds lock; one more drops it
    sendWord(1); sendWord(0); sendWord(0);
    sendWord(1); sendWord(1); sendWord(1);
    expectSync(1, "R7 good pair cancels one violation");
    sendWord(1);
    expectSync(0, "R7 loss after cancelled count reaches four");

    // R7 broken good run: bad, good, bad, bad, bad drops lock
    acquire("R9 reacquire");
    sendWord(1); sendWord(0); sendWord(1); sendWord(1);
    expectSync(1, "R7 single good word cancels nothing");
    sendWord(1);
    expectSync(0, "R7 single good word cancels nothing");

    // R7 floor at zero: many good words bank no credit
    acquire("R9 reacquire");
    for (int i = 0; i < 6; i++) sendWord(0);
    loseSync("R7 count floor at zero");

    // R3 code violation during hunt
    sendIdle(); sendIdle(-1); sendIdle(2, 0);
    sendIdle(); sendIdle();
    expectSync(0, "R3 violation clears set count");
    sendIdle();
    expectSync(1, "R3 clean sets after violation");
    loseSync("R6 loss via misaligned comma");

    // R3 misaligned comma during hunt
    sendIdle(); sendIdle(0, 1);
    sendIdle(); sendIdle();
    expectSync(0, "R3 misaligned comma clears set count");
    sendIdle();
    expectSync(1, "R3 misaligned comma recovery");
    loseSync("R6 loss");

    // R4 valid non-idle word between sets
    sendIdle(); sendIdle(); sendWord(0);
    sendIdle(); sendIdle();
    expectSync(0, "R4 non-idle word breaks sets");
    sendIdle();
    expectSync(1, "R4 sets after non-idle word");
    loseSync("R6 loss");

    // R4 non-idle character mid-set
    sendIdle();
    sendChar(1, 8'hBC, 1, 0, 0, 1); sendChar(0, 8'h95, 0, 0, 0, 0);
    sendChar(0, 8'h4A, 0, 0, 0, 0); sendChar(0, 8'hB5, 0, 0, 0, 0);
    sendIdle(); sendIdle();
    expectSync(0, "R4 wrong character mid-set");
    sendIdle();
    expectSync(1, "R4 recovery after wrong character");
    loseSync("R6 loss");

    // R5 set shifted by one slot does not count
    sendChar(0, 8'h4A, 0, 0, 0, 1);
    sendChar(1, 8'hBC, 1, 0, 0, 0); sendChar(0, 8'h95, 0, 0, 0, 0);
    sendChar(0, 8'hB5, 0, 0, 0, 0); sendChar(0, 8'hB5, 0, 0, 0, 0);
    sendIdle(); sendIdle();
    expectSync(0, "R5 misaligned set ignored");
    sendIdle();
    expectSync(1, "R5 aligned sets lock");

    // R10 words framed without boundary strobe
    loseSync("R10 loss with free-running framing", 0);

    // R10 gaps in charValid do not consume slots
    sendIdle(-1, 0, 2); sendIdle(-1, 0, 3);
    expectSync(0, "R10 gaps hold hunt state");
    sendIdle(-1, 0, 1);
    expectSync(1, "R10 lock with gaps");
    gap(5);
    expectSync(1, "R10 lock held across idle cycles");

    gap(2);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule